// File: doc/BRIEF.md
# Four-Phase Read Handshake Controller

This block links a bus master that asks for a read to a device that answers through a four-phase request/acknowledge pair. The master raises `bus_req`. The controller raises `dev_req` toward the device. The device answers on `dev_ack`. The controller then opens the data latch with `latch_en` and acknowledges the master on `bus_ack`. When the master withdraws its request, the latch closes. After that, the device request and the bus acknowledge return to zero together, and the device finally releases `dev_ack`.

The master may start its next request before the device has released `dev_ack`. Seen on the external pins alone, that moment looks the same as a request waiting for `dev_req`. A hidden phase bit tells the two situations apart. The phase bit sets on a request that arrives while `dev_ack` is low. It clears as soon as the request is withdrawn. Every output and the phase bit is a set/clear cell of the form `q <= set | (q & ~clear)`. The set and clear terms of a cell are never active together. Each cell reacts to the clock edge that samples its cause, so the design is the registered equivalent of a speed-independent controller.

Top module: `rd_handshake_ctrl`

## Requirements
- R1: A high `rst` sampled at a rising edge clears `dev_req`, `latch_en`, `bus_ack` and the phase bit at that edge, whatever the inputs are.
- R2: When `bus_req` is sampled high with `dev_ack` low, starting from idle, the phase bit sets at that edge and `dev_req` rises at the following edge. The first edge leaves `dev_req` low.
- R3: `latch_en` rises at the first edge that samples `dev_ack` high while the phase bit is set.
- R4: `bus_ack` copies `latch_en` one edge later, for both the rising and the falling transition.
- R5: When `bus_req` is sampled low, the phase bit clears at that edge and `latch_en` falls at the next edge. `latch_en` stays high through the first of those edges.
- R6: `dev_req` and `bus_ack` both fall at the edge after `latch_en` falls, which is the third edge after `bus_req` goes low.
- R7: If `bus_req` rises again while `dev_ack` is still high, `dev_req` stays low for as long as `dev_ack` stays high. It rises at the second edge after `dev_ack` is sampled low.
- R8: No output changes while the controller is waiting for its environment: `dev_req` alone during the wait for the device, all three outputs during the wait for the master, and no output during the device release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Read request from the bus master |
| dev_ack | input | 1 | Acknowledge from the device |
| bus_ack | output | 1 | Acknowledge to the bus master |
| dev_req | output | 1 | Request to the device |
| latch_en | output | 1 | Data latch enable |

## Verification
Every result has a fixed latency in clock edges, counted from the edge that samples the causing input:
- `dev_req` rises two edges after a request accepted with `dev_ack` low.
- `latch_en` rises one edge after `dev_ack` goes high.
- `bus_ack` follows `latch_en` by one edge.
- After a request is withdrawn, `latch_en` falls after two edges, and `dev_req` and `bus_ack` fall after three.

The bench changes inputs on falling edges and samples the three outputs on the next falling edge after each rising edge, so each check lands on the exact edge where its change is due. It also checks the edges just before, where nothing may have changed yet. Randomly drawn wait lengths check that the outputs hold steady for the whole time the environment takes to answer.

// File: rtl/rdh_pkg.sv
package rdh_pkg;

    localparam int NSIG      = 4;
    localparam int IDX_PHASE = 0;
    localparam int IDX_LATCH = 1;
    localparam int IDX_DREQ  = 2;
    localparam int IDX_BACK  = 3;

    typedef struct packed {
        logic back;
        logic dreq;
        logic latch;
        logic phase;
    } ctl_state_t;

    typedef struct packed {
        logic set;
        logic clr;
    } sr_pair_t;

    function automatic logic sr_next(input logic cur, input sr_pair_t t);
        return t.set | (cur & ~t.clr);
    endfunction

endpackage

// File: rtl/rdh_cover.sv
module rdh_cover
    import rdh_pkg::*;
(
    input  ctl_state_t                st,
    input  logic                      bus_req,
    input  logic                      dev_ack,
    output sr_pair_t [NSIG-1:0]       cov
);
    always_comb begin
        cov[IDX_PHASE].set = bus_req & ~dev_ack;
        cov[IDX_PHASE].clr = ~bus_req;

        cov[IDX_LATCH].set = dev_ack & st.phase;
        cov[IDX_LATCH].clr = ~dev_ack | ~st.phase;

        cov[IDX_DREQ].set  = st.phase;
        cov[IDX_DREQ].clr  = ~st.phase & ~st.latch;

        cov[IDX_BACK].set  = st.latch;
        cov[IDX_BACK].clr  = ~st.latch;
    end
endmodule

// File: rtl/rdh_sr_cell.sv
module rdh_sr_cell
    import rdh_pkg::*;
#(
    parameter logic RST_VAL = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  sr_pair_t term,
    output logic     q
);
    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= sr_next(q, term);
    end
endmodule

// File: rtl/rd_handshake_ctrl.sv
module rd_handshake_ctrl
    import rdh_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bus_req,
    input  logic dev_ack,
    output logic bus_ack,
    output logic dev_req,
    output logic latch_en
);
    logic [NSIG-1:0]      q_vec;
    ctl_state_t           st;
    sr_pair_t [NSIG-1:0]  cov;
    logic                 phase_q;

    assign st      = q_vec;
    assign phase_q = st.phase;

    rdh_cover u_cover (
        .st      (st),
        .bus_req (bus_req),
        .dev_ack (dev_ack),
        .cov     (cov)
    );

    for (genvar i = 0; i < NSIG; i++) begin : g_cell
        rdh_sr_cell #(.RST_VAL(1'b0)) u_cell (
            .clk  (clk),
            .rst  (rst),
            .term (cov[i]),
            .q    (q_vec[i])
        );
    end

    assign latch_en = st.latch;
    assign dev_req  = st.dreq;
    assign bus_ack  = st.back;
endmodule

// File: rtl/rdh_chk.sv
module rdh_chk (
    input logic clk,
    input logic rst,
    input logic bus_req,
    input logic dev_ack,
    input logic bus_ack,
    input logic dev_req,
    input logic latch_en,
    input logic phase_q
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!dev_req && !latch_en && !bus_ack && !phase_q)); // R1

    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ($rose(dev_req) && !$past(rst) && !$past(rst, 2))
        |-> ($past(bus_req, 2) && !$past(dev_ack, 2))); // R7

    AST_LATCH_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ($rose(latch_en) && !$past(rst)) |-> ($past(dev_ack) && $past(phase_q))); // R3

    AST_ACK_RISE: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_ack) && !$past(rst)) |-> $past(latch_en)); // R4

    AST_ACK_FALL: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_ack) && !$past(rst)) |-> !$past(latch_en)); // R4

    AST_LATCH_CLOSE: assert property (@(posedge clk) disable iff (rst)
        ($fell(latch_en) && !$past(rst)) |-> !$past(phase_q)); // R5

    AST_RETURN_PAIR: assert property (@(posedge clk) disable iff (rst)
        ($fell(dev_req) && !$past(rst)) |-> $fell(bus_ack)); // R6

    AST_NO_EARLY_DROP: assert property (@(posedge clk) disable iff (rst)
        ($fell(dev_req) && !$past(rst)) |-> (!$past(latch_en) && !$past(phase_q))); // R8
endmodule

bind rd_handshake_ctrl rdh_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_req  (bus_req),
    .dev_ack  (dev_ack),
    .bus_ack  (bus_ack),
    .dev_req  (dev_req),
    .latch_en (latch_en),
    .phase_q  (phase_q)
);

// File: tb/rd_handshake_ctrl_tb.sv
`timescale 1ns/1ps
module rd_handshake_ctrl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_req = 1'b0;
    logic dev_ack = 1'b0;
    logic bus_ack, dev_req, latch_en;
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    bit   pending;

    always #4 clk = ~clk;

    rd_handshake_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .dev_ack(dev_ack),
        .bus_ack(bus_ack), .dev_req(dev_req), .latch_en(latch_en)
    );

    function automatic logic [2:0] pat(bit r, bit l, bit a);
        return {r, l, a};
    endfunction

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic chk(string tag, logic [2:0] exp);
        logic [2:0] act;
        act = {dev_req, latch_en, bus_ack};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual={dev_req,latch_en,bus_ack}=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic accept();
        bus_req = 1'b1;
        step(); chk("R2 first edge", pat(0, 0, 0));
        step(); chk("R2 second edge", pat(1, 0, 0));
    endtask

    task automatic serve(int d1, int d2);
        repeat (d1) begin step(); chk("R8 wait device", pat(1, 0, 0)); end
        dev_ack = 1'b1;
        step(); chk("R3 latch open", pat(1, 1, 0));
        step(); chk("R4 ack rise", pat(1, 1, 1));
        repeat (d2) begin step(); chk("R8 wait bus", pat(1, 1, 1)); end
        bus_req = 1'b0;
        step(); chk("R5 first edge", pat(1, 1, 1));
        step(); chk("R5 latch close", pat(1, 0, 1));
        step(); chk("R6 return pair", pat(0, 0, 0));
    endtask

    task automatic release_dev(int d3, bit early);
        if (early) bus_req = 1'b1;
        repeat (d3) begin
            step();
            chk(early ? "R7 hold while dev_ack high" : "R8 device release", pat(0, 0, 0));
        end
        dev_ack = 1'b0;
        if (early) begin
            step(); chk("R7 first edge", pat(0, 0, 0));
            step(); chk("R7 second edge", pat(1, 0, 0));
        end else begin
            step(); chk("R8 idle", pat(0, 0, 0));
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<=50000 cycles", cyc);
            report();
        end
    end

    initial begin
        void'($urandom(32'd7741));
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        step(); chk("R1 after reset", pat(0, 0, 0));

        // directed: shortest cycle
        accept(); serve(0, 0); release_dev(0, 1'b0);
        // directed: early request with device still acknowledging
        accept(); serve(2, 1); release_dev(3, 1'b1);
        serve(0, 0); release_dev(1, 1'b0);

        // directed: reset in the middle of a cycle
        accept();
        dev_ack = 1'b1;
        step(); chk("R3 before reset", pat(1, 1, 0));
        rst = 1'b1;
        step(); chk("R1 mid-cycle reset", pat(0, 0, 0));
        rst = 1'b0; dev_ack = 1'b0; bus_req = 1'b0;
        step(); chk("R1 stays idle", pat(0, 0, 0));

        // random delays
        pending = 1'b0;
        for (int n = 0; n < 80; n++) begin
            bit early;
            if (!pending) begin
                repeat ($urandom_range(0, 3)) begin step(); chk("R8 idle gap", pat(0, 0, 0)); end
                accept();
            end
            serve($urandom_range(0, 5), $urandom_range(0, 5));
            early = ($urandom_range(0, 2) == 0);
            release_dev($urandom_range(1, 4), early);
            pending = early;
        end
        if (pending) begin
            serve(1, 1);
            release_dev(1, 1'b0);
        end
        report();
    end
endmodule